// File: doc/BRIEF.md
# Instruction-Pair Fetch Sequencer

This block is the instruction fetch front end of a small stored-program processor. Every 40-bit memory word carries two 20-bit instructions. Each instruction is an 8-bit opcode followed by a 12-bit operand address. The program counter selects a whole word, which holds a pair of instructions, not a single instruction.

On a fetch request, the block reads the word at the program counter over a synchronous read port with one cycle of latency. It keeps the full word in a memory buffer register and issues the left instruction as an opcode and an operand address. It holds the right instruction in an instruction buffer. The next request is then served from that buffer with no memory access, and the program counter moves to the next pair.

A program counter load port handles branches. It discards the buffered instruction and can direct the next fetch to issue only the right half of the target word. A busy output tells the requester to wait while a memory read is outstanding.

Top module: `pairFetch`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `issueValid`, `busy` and `memRdEn` are 0 and `mbrWord` is 0. The first fetch after reset reads word 0.
- R2: A fetch request with an empty buffer drives `memRdEn` high for exactly one cycle, with `memRdAddr` equal to the program counter. `issueValid` then rises two cycles after `memRdEn`, carrying the left instruction: opcode = data[39:32], address = data[31:20], `issueRight` = 0.
- R3: A fetch request with a full buffer performs no memory read. In the next cycle it issues the buffered right instruction: opcode = data[19:12], address = data[11:0], `issueRight` = 1.
- R4: Issuing a right instruction increments the program counter by one. The program counter stays constant while a read is outstanding.
- R5: The program counter wraps from MEM_DEPTH-1 (999) to 0, and `memRdAddr` never reaches MEM_DEPTH.
- R6: `busy` is high from the cycle after an accepted read request until the issue cycle. Requests made while `busy` is high are ignored. `issueValid` is never high together with `busy`.
- R7: `mbrWord` holds the full 40-bit fetched word unchanged, including the sign bit 39. It changes only when a word is read.
- R8: A program counter load with `pcHalf` = 0 sets the program counter to `pcTarget` and empties the buffer. The next fetch reads the target word and issues its left instruction.
- R9: A program counter load with `pcHalf` = 1 makes the next fetch issue only the right instruction of the target word. The program counter then increments, and the buffer stays empty.
- R10: A `pcTarget` of MEM_DEPTH or more loads 0.
- R11: A program counter load while `busy` is high is ignored. When a load and a fetch request arrive together in an idle cycle, the load wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | Request for the next instruction |
| pcLoad | input | 1 | Branch: load program counter |
| pcTarget | input | 10 | Branch target word index |
| pcHalf | input | 1 | Branch target half, 1 = right instruction |
| memRdEn | output | 1 | Memory read enable |
| memRdAddr | output | 10 | Memory read word address |
| memRdData | input | 40 | Read data, valid one cycle after `memRdEn` |
| busy | output | 1 | Read outstanding; new requests are ignored |
| issueValid | output | 1 | Instruction issue strobe |
| issueOpcode | output | 8 | Issued opcode (instruction register) |
| issueAddr | output | 12 | Issued operand address (memory address register) |
| issueRight | output | 1 | Issued instruction was a right half |
| mbrWord | output | 40 | Memory buffer register contents |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each.
- Alternating buffer hits and misses: a design that loses the buffer state would read memory again, or issue the left half twice.
- The wrap at word 999: a wrong design would present address 1000.
- A branch into a right half: a wrong design would issue the stale left instruction, or leave the buffer full.
- A target beyond the memory: a wrong design would load it unchanged.
- Loads and requests held during a read, or arriving together with each other: a design with the wrong priority would restart the fetch mid-read, or serve the request instead of the branch.

A behavioural model runs beside the design, and every issue, read strobe and buffer word is compared with it on every cycle.

// File: rtl/pairFetchPkg.sv
package pairFetchPkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic loadPc;    // take branch target
    logic capWord;   // capture memory read data
    logic takeRight; // with capWord: issue right half instead of left
    logic useIbr;    // issue from instruction buffer
    logic incPc;     // advance to next pair
  } fetchStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DATA
  } fetchStateT;

endpackage

// File: rtl/pairFetchCtrl.sv
module pairFetchCtrl
  import pairFetchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchReq,
  input  logic        pcLoad,
  input  logic        pcHalf,
  output fetchStrobeT strb,
  output logic        busy,
  output logic        memRdEn,
  output logic        issueValid
);

  fetchStateT state, nextState;
  logic bufValid;
  logic skipLeft;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (pcLoad) begin
          strb.loadPc = 1'b1;
        end else if (fetchReq) begin
          if (bufValid) begin
            strb.useIbr = 1'b1;
            strb.incPc  = 1'b1;
          end else begin
            nextState = ST_READ;
          end
        end
      end
      ST_READ: nextState = ST_DATA;
      ST_DATA: begin
        strb.capWord   = 1'b1;
        strb.takeRight = skipLeft;
        strb.incPc     = skipLeft;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      issueValid <= 1'b0;
      bufValid   <= 1'b0;
      skipLeft   <= 1'b0;
    end else begin
      state      <= nextState;
      issueValid <= strb.capWord | strb.useIbr;
      if (strb.loadPc) begin
        bufValid <= 1'b0;
        skipLeft <= pcHalf;
      end else if (strb.useIbr) begin
        bufValid <= 1'b0;
      end else if (strb.capWord) begin
        bufValid <= ~skipLeft;
        skipLeft <= 1'b0;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign memRdEn = (state == ST_READ);

endmodule

// File: rtl/pairFetchPath.sv
module pairFetchPath
  import pairFetchPkg::*;
#(
  parameter int WORD_W    = 40,
  parameter int OP_W      = 8,
  parameter int ADDR_W    = 12,
  parameter int MEM_DEPTH = 1000,
  localparam int INSN_W   = WORD_W / 2,
  localparam int PC_W     = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobeT       strb,
  input  logic [PC_W-1:0]   pcTarget,
  input  logic [WORD_W-1:0] memRdData,
  output logic [PC_W-1:0]   pcQ,
  output logic [OP_W-1:0]   irQ,
  output logic [ADDR_W-1:0] marQ,
  output logic              issueRightQ,
  output logic [WORD_W-1:0] mbrQ
);

  logic [INSN_W-1:0] half [2];
  logic [INSN_W-1:0] ibrQ;
  logic [INSN_W-1:0] issueInsn;
  logic [PC_W-1:0]   pcInc;
  logic [PC_W-1:0]   pcLoadVal;

  // half[0] is the left (upper) instruction, half[1] the right
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = memRdData[WORD_W-1-h*INSN_W -: INSN_W];
  end

  assign pcInc     = (int'(pcQ) == MEM_DEPTH - 1) ? '0 : pcQ + 1'b1;
  assign pcLoadVal = (int'(pcTarget) >= MEM_DEPTH) ? '0 : pcTarget;

  always_comb begin
    if (strb.useIbr)         issueInsn = ibrQ;
    else if (strb.takeRight) issueInsn = half[1];
    else                     issueInsn = half[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ         <= '0;
      irQ         <= '0;
      marQ        <= '0;
      issueRightQ <= 1'b0;
      mbrQ        <= '0;
      ibrQ        <= '0;
    end else begin
      if (strb.loadPc)     pcQ <= pcLoadVal;
      else if (strb.incPc) pcQ <= pcInc;
      if (strb.capWord) begin
        mbrQ <= memRdData;
        ibrQ <= half[1];
      end
      if (strb.capWord || strb.useIbr) begin
        irQ         <= issueInsn[INSN_W-1 -: OP_W];
        marQ        <= issueInsn[ADDR_W-1:0];
        issueRightQ <= strb.useIbr | strb.takeRight;
      end
    end
  end

endmodule

// File: rtl/pairFetch.sv
module pairFetch
  import pairFetchPkg::*;
#(
  parameter int WORD_W    = 40,
  parameter int OP_W      = 8,
  parameter int ADDR_W    = 12,
  parameter int MEM_DEPTH = 1000,
  localparam int PC_W     = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic              pcLoad,
  input  logic [PC_W-1:0]   pcTarget,
  input  logic              pcHalf,
  output logic              memRdEn,
  output logic [PC_W-1:0]   memRdAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              busy,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOpcode,
  output logic [ADDR_W-1:0] issueAddr,
  output logic              issueRight,
  output logic [WORD_W-1:0] mbrWord
);

  fetchStrobeT strb;

  pairFetchCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .fetchReq   (fetchReq),
    .pcLoad     (pcLoad),
    .pcHalf     (pcHalf),
    .strb       (strb),
    .busy       (busy),
    .memRdEn    (memRdEn),
    .issueValid (issueValid)
  );

  pairFetchPath #(
    .WORD_W    (WORD_W),
    .OP_W      (OP_W),
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) path_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pcTarget    (pcTarget),
    .memRdData   (memRdData),
    .pcQ         (memRdAddr),
    .irQ         (issueOpcode),
    .marQ        (issueAddr),
    .issueRightQ (issueRight),
    .mbrQ        (mbrWord)
  );

endmodule

// File: rtl/pairFetchChk.sv
module pairFetchChk #(
  parameter int MEM_DEPTH = 1000,
  parameter int PC_W      = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            memRdEn,
  input logic            issueValid,
  input logic [PC_W-1:0] memRdAddr
);

  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn && busy));

  assert_rd_to_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> ##1 issueValid);

  assert_issue_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (!busy && !memRdEn));

  assert_rd_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(memRdAddr) < MEM_DEPTH);

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memRdAddr));

endmodule

bind pairFetch pairFetchChk #(
  .MEM_DEPTH (MEM_DEPTH),
  .PC_W      (PC_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .memRdEn    (memRdEn),
  .issueValid (issueValid),
  .memRdAddr  (memRdAddr)
);

// File: tb/pairFetch_tb_top.sv
`timescale 1ns/1ps
module pairFetch_tb_top;

  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic        pcLoad = 1'b0;
  logic [9:0]  pcTarget = '0;
  logic        pcHalf = 1'b0;
  logic        memRdEn;
  logic [9:0]  memRdAddr;
  logic [39:0] memRdData = '0;
  logic        busy;
  logic        issueValid;
  logic [7:0]  issueOpcode;
  logic [11:0] issueAddr;
  logic        issueRight;
  logic [39:0] mbrWord;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  always #10 clk = ~clk;

  pairFetch dut_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .pcLoad(pcLoad),
    .pcTarget(pcTarget), .pcHalf(pcHalf), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .busy(busy),
    .issueValid(issueValid), .issueOpcode(issueOpcode),
    .issueAddr(issueAddr), .issueRight(issueRight), .mbrWord(mbrWord)
  );

  function automatic logic [39:0] memWord(int a);
    return {8'(a * 37 + 5), 12'(a * 91 + 3), 8'(a * 13 + 200), 12'(a * 7 + 1000)};
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memWord(int'(memRdAddr));

  // behavioural reference model
  int          mPc = 0;
  bit          mBuf = 0;
  bit          mSkip = 0;
  int          mWait = 0;
  logic [19:0] mIbr = '0;
  bit          expValid = 0;
  logic [7:0]  expOp = '0;
  logic [11:0] expAd = '0;
  bit          expRight = 0;
  logic [39:0] expMbr = '0;

  always @(posedge clk) begin
    logic [39:0] w;
    if (!rstN) begin
      mPc = 0; mBuf = 0; mSkip = 0; mWait = 0; expValid = 0; expMbr = '0;
    end else begin
      expValid = 0;
      if (mWait == 2) begin
        mWait = 1;
      end else if (mWait == 1) begin
        w = memWord(mPc);
        expMbr = w;
        if (mSkip) begin
          expOp = w[19:12]; expAd = w[11:0]; expRight = 1;
          mPc = (mPc + 1) % DEPTH; mBuf = 0;
        end else begin
          expOp = w[39:32]; expAd = w[31:20]; expRight = 0;
          mIbr = w[19:0]; mBuf = 1;
        end
        mSkip = 0; mWait = 0; expValid = 1;
      end else if (pcLoad) begin
        mPc = (int'(pcTarget) >= DEPTH) ? 0 : int'(pcTarget);
        mSkip = pcHalf; mBuf = 0;
      end else if (fetchReq) begin
        if (mBuf) begin
          expOp = mIbr[19:12]; expAd = mIbr[11:0]; expRight = 1;
          mPc = (mPc + 1) % DEPTH; mBuf = 0; expValid = 1;
        end else begin
          mWait = 2;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (during %s) %s: actual=%0h expected=%0h at %0t",
               req, curTag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(busy == (mWait != 0), "R6", "busy", 40'(busy), 40'(mWait != 0));
      check(memRdEn == (mWait == 2), "R2", "memRdEn", 40'(memRdEn), 40'(mWait == 2));
      if (mWait == 2)
        check(int'(memRdAddr) == mPc, "R4", "memRdAddr", 40'(memRdAddr), 40'(mPc));
      check(issueValid == expValid, "R6", "issueValid", 40'(issueValid), 40'(expValid));
      check(mbrWord == expMbr, "R7", "mbrWord", mbrWord, expMbr);
      if (expValid && issueValid) begin
        check(issueOpcode == expOp, expRight ? "R3" : "R2", "opcode", 40'(issueOpcode), 40'(expOp));
        check(issueAddr == expAd, expRight ? "R3" : "R2", "operand", 40'(issueAddr), 40'(expAd));
        check(issueRight == expRight, "R3", "issueRight", 40'(issueRight), 40'(expRight));
      end
    end
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reqOnce();
    @(negedge clk); fetchReq = 1'b1;
    @(negedge clk); fetchReq = 1'b0;
    waitIdle();
  endtask

  task automatic loadPc(int t, bit h);
    @(negedge clk); pcLoad = 1'b1; pcTarget = 10'(t); pcHalf = h;
    @(negedge clk); pcLoad = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R2";  reqOnce();
    curTag = "R3";  reqOnce();
    curTag = "R4";  reqOnce(); reqOnce(); reqOnce();
    curTag = "R6";
    @(negedge clk); fetchReq = 1'b1;
    repeat (9) @(negedge clk);
    fetchReq = 1'b0; waitIdle();
    curTag = "R8";  loadPc(500, 1'b0); reqOnce(); reqOnce(); reqOnce();
    curTag = "R9";  loadPc(37, 1'b1); reqOnce(); reqOnce();
    curTag = "R5";  loadPc(DEPTH - 1, 1'b0); reqOnce(); reqOnce(); reqOnce();
    loadPc(DEPTH - 1, 1'b1); reqOnce(); reqOnce();
    curTag = "R10"; loadPc(1020, 1'b0); reqOnce(); reqOnce();
    curTag = "R11";
    loadPc(200, 1'b0);
    @(negedge clk); fetchReq = 1'b1;
    @(negedge clk); fetchReq = 1'b0; pcLoad = 1'b1; pcTarget = 10'd5; pcHalf = 1'b1;
    @(negedge clk); pcLoad = 1'b0;
    waitIdle();
    reqOnce();
    @(negedge clk); fetchReq = 1'b1; pcLoad = 1'b1; pcTarget = 10'd77; pcHalf = 1'b0;
    @(negedge clk); fetchReq = 1'b0; pcLoad = 1'b0;
    waitIdle();
    reqOnce(); reqOnce();
    curTag = "R1";
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    reqOnce();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule